// File: doc/BRIEF.md
# Universal Shift/Rotate Register

This block is a small word register that, on every rising clock edge, replaces its contents with one of six results picked by a three-bit operation code. It can take a new word from a parallel input, move its bits one place toward the most significant end or toward the least significant end, and either fill the vacated end with zero or wrap the bit that leaves around to the other end. It can also preset every bit to one. The stored word is always visible on a parallel output.

Each bit of the word is a flop fed by a four-way source selector. The two upper bits of the operation code choose the source: parallel input, lower neighbour, upper neighbour or constant one. The lowest code bit only decides what enters at the two end positions: zero for a plain shift, the wrapped bit for a rotate. An active-low asynchronous clear empties the register at any time, and an active-high enable freezes the contents whatever code is presented.

Top module: `univ_shreg`

## Requirements
- R1: When `rst_n` is 0 the output `dout` is all zeros at once, without waiting for a clock edge, and it stays zero through clock edges for as long as `rst_n` is 0, whatever `en`, `fsel` and `pdata` are.
- R2: At a rising edge with `en` = 0 the contents are kept unchanged for any `fsel` and `pdata`.
- R3: At a rising edge with `en` = 1 and `fsel` = 000 or 001, `dout` takes the value of `pdata` (bit i of `pdata` goes to bit i).
- R4: With `en` = 1 and `fsel` = 010, bit i+1 takes the old bit i and bit 0 takes 0 (shift toward the MSB); for a 4-bit word a3 a2 a1 a0 becomes a2 a1 a0 0.
- R5: With `en` = 1 and `fsel` = 011, bit i+1 takes the old bit i and bit 0 takes the old MSB; a3 a2 a1 a0 becomes a2 a1 a0 a3.
- R6: With `en` = 1 and `fsel` = 100, bit i takes the old bit i+1 and the MSB takes 0 (shift toward the LSB); a3 a2 a1 a0 becomes 0 a3 a2 a1.
- R7: With `en` = 1 and `fsel` = 101, bit i takes the old bit i+1 and the MSB takes the old bit 0; a3 a2 a1 a0 becomes a0 a3 a2 a1.
- R8: With `en` = 1 and `fsel` = 110 or 111, every bit becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| en | input | 1 | Update enable, active high |
| fsel | input | 3 | Operation code (bit 2, bit 1 pick source; bit 0 picks end fill) |
| pdata | input | WIDTH | Parallel load word |
| dout | output | WIDTH | Stored word |

## Verification
The two functions that can meet in one cycle are the asynchronous clear and a clocked update: the bench presents the set-to-ones code with the enable high, drops `rst_n` between two edges, and checks that the output is zero immediately and is still zero after the following edge, so the clear wins over the pending preset. The scoreboard then resumes from a zero model after release. Enable-low cycles are paired with every kind of code so that a hold which leaks a shift or load shows up at the output on the next edge.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    // Source chosen for every bit by the two upper operation bits.
    typedef enum logic [1:0] {
        SRC_PAR  = 2'b00,
        SRC_LOW  = 2'b01,
        SRC_HIGH = 2'b10,
        SRC_ONES = 2'b11
    } src_sel_e;

    localparam int FSEL_W = 3;

endpackage

// File: rtl/shreg_edgefill.sv
module shreg_edgefill (
    input  logic msb_q,
    input  logic lsb_q,
    input  logic wrap,
    output logic fill_lo,
    output logic fill_hi
);

    // Value entering the vacated end: zero for a shift, wrapped bit for a rotate.
    always_comb begin
        fill_lo = wrap ? msb_q : 1'b0;
        fill_hi = wrap ? lsb_q : 1'b0;
    end

endmodule

// File: rtl/shreg_bitmux.sv
module shreg_bitmux
    import shreg_pkg::*;
(
    input  src_sel_e sel,
    input  logic     par_bit,
    input  logic     low_bit,
    input  logic     high_bit,
    output logic     nxt_bit
);

    always_comb begin
        unique case (sel)
            SRC_PAR:  nxt_bit = par_bit;
            SRC_LOW:  nxt_bit = low_bit;
            SRC_HIGH: nxt_bit = high_bit;
            SRC_ONES: nxt_bit = 1'b1;
            default:  nxt_bit = par_bit;
        endcase
    end

endmodule

// File: rtl/univ_shreg.sv
module univ_shreg
    import shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [FSEL_W-1:0]   fsel,
    input  logic [WIDTH-1:0]    pdata,
    output logic [WIDTH-1:0]    dout
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } regs_t;

    regs_t regs_d, regs_q;

    src_sel_e         src_sel;
    logic             fill_lo, fill_hi;
    logic [WIDTH-1:0] from_low, from_high, mux_word;

    assign src_sel = src_sel_e'(fsel[2:1]);

    shreg_edgefill fill_i (
        .msb_q   (regs_q.word[MSB]),
        .lsb_q   (regs_q.word[0]),
        .wrap    (fsel[0]),
        .fill_lo (fill_lo),
        .fill_hi (fill_hi)
    );

    assign from_low  = {regs_q.word[MSB-1:0], fill_lo};
    assign from_high = {fill_hi, regs_q.word[MSB:1]};

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        shreg_bitmux mux_i (
            .sel      (src_sel),
            .par_bit  (pdata[i]),
            .low_bit  (from_low[i]),
            .high_bit (from_high[i]),
            .nxt_bit  (mux_word[i])
        );
    end

    always_comb begin
        regs_d = regs_q;
        if (en) begin
            regs_d.word = mux_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dout = regs_q.word;

endmodule

// File: rtl/shreg_chk.sv
module shreg_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [2:0]       fsel,
    input logic [WIDTH-1:0] pdata,
    input logic [WIDTH-1:0] dout
);

    assert_async_clear_R1: assert property (@(posedge clk)
        !rst_n |-> dout == '0);

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(dout));

    assert_parallel_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fsel[2:1] == 2'b00) |=> dout == $past(pdata));

    assert_shift_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fsel == 3'b010) |=> dout == {$past(dout[WIDTH-2:0]), 1'b0});

    assert_rotate_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fsel == 3'b011) |=> dout == {$past(dout[WIDTH-2:0]), $past(dout[WIDTH-1])});

    assert_shift_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fsel == 3'b100) |=> dout == {1'b0, $past(dout[WIDTH-1:1])});

    assert_rotate_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fsel == 3'b101) |=> dout == {$past(dout[0]), $past(dout[WIDTH-1:1])});

    assert_preset_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fsel[2:1] == 2'b11) |=> $countones(dout) == WIDTH);

endmodule

bind univ_shreg shreg_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/univ_shreg_tb_top.sv
module univ_shreg_tb_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [2:0]   fsel = 3'b000;
    logic [W-1:0] pdata = '0;
    logic [W-1:0] dout;

    typedef struct {
        logic [W-1:0] exp;
        string        req;
    } item_t;

    item_t        sb_q[$];
    logic [W-1:0] model = '0;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           finished = 1'b0;

    always #2 clk = ~clk;

    univ_shreg #(.WIDTH(W)) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .fsel  (fsel),
        .pdata (pdata),
        .dout  (dout)
    );

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: dout=%b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] predict(input logic [W-1:0] cur, input logic e,
                                             input logic [2:0] f, input logic [W-1:0] p);
        if (!e) return cur;
        case (f)
            3'b000, 3'b001: return p;
            3'b010: return {cur[W-2:0], 1'b0};
            3'b011: return {cur[W-2:0], cur[W-1]};
            3'b100: return {1'b0, cur[W-1:1]};
            3'b101: return {cur[0], cur[W-1:1]};
            default: return '1;
        endcase
    endfunction

    // Driver: present one operation at a falling edge and queue its outcome.
    task automatic apply(input logic e, input logic [2:0] f, input logic [W-1:0] p, input string req);
        item_t it;
        @(negedge clk);
        en = e; fsel = f; pdata = p;
        model = predict(model, e, f, p);
        it.exp = model;
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare shortly after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(dout, it.exp, it.req);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #80000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: dout=%b expected run completion", dout);
        finish_run();
    end

    initial begin
        // R1: reset state, held across edges with a preset pending
        en = 1'b1; fsel = 3'b110; pdata = 4'b1111;
        repeat (3) @(posedge clk);
        #1 check(dout, 4'b0000, "R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;
        en = 1'b0;

        apply(1, 3'b000, 4'b1010, "R3 load code 000");
        apply(1, 3'b001, 4'b0110, "R3 load code 001");
        apply(1, 3'b010, 4'b0000, "R4 shift up");
        apply(1, 3'b010, 4'b1111, "R4 shift up zero fill");
        apply(1, 3'b000, 4'b1001, "R3 load");
        apply(1, 3'b011, 4'b0000, "R5 rotate up wraps msb");
        apply(1, 3'b011, 4'b0000, "R5 rotate up");
        apply(1, 3'b000, 4'b1011, "R3 load");
        apply(1, 3'b100, 4'b1111, "R6 shift down");
        apply(1, 3'b100, 4'b0000, "R6 shift down zero fill");
        apply(1, 3'b000, 4'b0011, "R3 load");
        apply(1, 3'b101, 4'b0000, "R7 rotate down wraps lsb");
        apply(1, 3'b101, 4'b0000, "R7 rotate down");
        apply(0, 3'b010, 4'b0000, "R2 hold over shift");
        apply(0, 3'b000, 4'b0101, "R2 hold over load");
        apply(0, 3'b110, 4'b0000, "R2 hold over preset");
        apply(1, 3'b110, 4'b0000, "R8 preset code 110");
        apply(1, 3'b100, 4'b0000, "R6 shift down from ones");
        apply(1, 3'b111, 4'b0000, "R8 preset code 111");
        apply(1, 3'b101, 4'b0000, "R7 rotate all ones");
        apply(1, 3'b000, 4'b0001, "R3 load single bit");
        apply(1, 3'b011, 4'b0000, "R5 rotate up");
        apply(1, 3'b011, 4'b0000, "R5 rotate up");
        apply(1, 3'b011, 4'b0000, "R5 rotate up");
        apply(1, 3'b011, 4'b0000, "R5 rotate up full circle");
        apply(0, 3'b011, 4'b0000, "R2 hold over rotate");

        @(negedge clk);
        en = 1'b0;
        repeat (2) @(posedge clk);
        #1.5;

        // R1: clear arriving between edges while a preset is selected
        @(negedge clk);
        en = 1'b1; fsel = 3'b110; pdata = 4'b0000;
        #0.5 rst_n = 1'b0;
        #0.5 check(dout, 4'b0000, "R1 clear between edges");
        @(posedge clk);
        #1 check(dout, 4'b0000, "R1 clear beats preset at edge");
        @(negedge clk);
        rst_n = 1'b1;
        en = 1'b0;
        model = '0;

        apply(1, 3'b111, 4'b0000, "R8 preset after clear");
        apply(1, 3'b010, 4'b0000, "R4 shift up from ones");

        @(negedge clk);
        en = 1'b0;
        repeat (3) @(posedge clk);
        #1.5;
        finish_run();
    end

endmodule